// File: doc/BRIEF.md
# MAC Result Path: Overflow, Saturation and Rounding

This block is the back end of a multiply-accumulate datapath. One 64-bit operand is presented per transaction together with an operation code, an accumulator index and five mode pins. Depending on the operation, the operand is treated as a raw multiplier product, an extended accumulator sum, an accumulator whose condition flags are wanted, or an accumulator being read back as a 32-bit value. The block returns the processed word on a registered result channel and keeps a set of condition flags. Among these flags is one sticky overflow bit for each of the four accumulators.

The input channel uses valid/ready. A transaction is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result register is empty or is being drained in the same cycle. The result appears with `res_valid` one cycle after acceptance. It stays there unchanged until `res_ready` is seen high, so a stalled consumer back-pressures the producer with no loss. The flags are plain outputs. They update on the same edge that loads the result. A `flag_clr` pulse stands for a status-register write that clears them.

Operation codes are MUL=0, SAT=1, FLAGS=2 and READ=3. The mode pins are `mode_frac` (fractional, which takes precedence over signed), `mode_signed` (signed integer when high, unsigned integer when both it and `mode_frac` are low), `mode_round`, `mode_half` and `mode_sat`.

Top module: `mac_result_path`

## Requirements
- R1: While reset is held and on the first cycle after it, `res_valid` is low, `in_ready` is high, and Z, N, V, EV and all four accumulator overflow bits are zero.
- R2: An accepted transaction makes `res_valid` high on the next edge. While `res_valid` is high and `res_ready` is low, `res_data` is held and `in_ready` is low.
- R3: MUL in signed or fractional mode: an operand outside the signed 40-bit range sets V. With `mode_sat` the result becomes +2^50, or -2^50 for a negative operand. Without it, the result is the low 40 bits sign-extended. An operand in range passes unchanged.
- R4: MUL in unsigned mode: any set bit at position 40 or above sets V. The result is then 2^50 with `mode_sat`, or the low 40 bits zero-extended without it. Otherwise the operand passes unchanged.
- R5: SAT in signed or fractional mode: an operand outside the signed 48-bit range sets V and the overflow bit of accumulator `in_sel`. With `mode_sat` the result is clamped, by the operand's sign, to the 48-bit extremes in fractional mode and to the 32-bit extremes in signed mode. Without it, the result is the low 48 bits sign-extended.
- R6: SAT in unsigned mode: any set bit at position 48 or above sets V and the selected accumulator's overflow bit. The result is 2^48-1 with `mode_sat`, or else the low 48 bits.
- R7: FLAGS takes the low 48 bits of the operand. Z is set when they are all zero and N when bit 47 is set. V is additionally set if the selected accumulator's overflow bit is set. `res_data` is zero.
- R8: FLAGS sets EV in these cases. In fractional mode, bits 47..40 are neither all zero nor all one. In signed mode, bits 47..32 are neither all zero nor all one. In unsigned mode, any of bits 47..32 is set.
- R9: READ in fractional mode with `mode_half`: the operand is shifted arithmetically right by 24 and rounded half-to-even on the 24 discarded bits. With `mode_sat` the value is clamped to the signed 16-bit extremes. The 16-bit result is zero-extended.
- R10: READ in fractional mode without `mode_half`: the operand is shifted arithmetically right by 8. When `mode_round` is set, it is rounded half-to-even on the 8 discarded bits; otherwise it is truncated. With `mode_sat` the value is clamped to the signed 32-bit extremes. The 32-bit result is zero-extended.
- R11: READ in signed integer mode returns the low 32 bits when the operand fits a signed 32-bit value, and otherwise 0x7FFFFFFF or 0x80000000 by its sign. In unsigned mode it returns the low 32 bits when bits 63..32 are zero, and otherwise 0xFFFFFFFF. Every READ result has bits 63..32 zero.
- R12: V and the four overflow bits are sticky until `flag_clr`. `flag_clr` clears V, EV, Z, N and the overflow bits first; an operation accepted on the same edge then applies its own updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand transaction valid |
| in_ready | output | 1 | Block can take a transaction this cycle |
| in_op | input | 2 | Operation: MUL=0, SAT=1, FLAGS=2, READ=3 |
| in_sel | input | 2 | Accumulator index |
| in_val | input | 64 | Operand (product or sign-extended accumulator) |
| mode_frac | input | 1 | Fractional mode |
| mode_signed | input | 1 | Signed integer mode (ignored when fractional) |
| mode_round | input | 1 | Round the 32-bit fractional read |
| mode_half | input | 1 | 16-bit fractional read |
| mode_sat | input | 1 | Saturate on overflow |
| flag_clr | input | 1 | Clear status flags |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 64 | Result word |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Sticky overflow flag |
| flag_ev | output | 1 | Extension-in-use flag |
| flag_pav | output | 4 | Sticky per-accumulator overflow bits |

## Verification
The properties assume that `in_valid`, `in_op`, `in_sel`, `res_ready` and `flag_clr` are never unknown after reset. They also assume that a pending transaction keeps its operand and modes until accepted, since the hold and acceptance properties count handshakes only at edges. The stimulus drives every control pin to a defined level from time zero and changes inputs only between edges. It keeps each offered transaction unchanged until the edge that takes it. Operands stay well inside the 64-bit range, so a rounding increment never wraps the full word.

// File: rtl/mac_rp_pkg.sv
package mac_rp_pkg;

  typedef enum logic [1:0] {
    OP_MUL   = 2'd0,
    OP_SAT   = 2'd1,
    OP_FLAGS = 2'd2,
    OP_READ  = 2'd3
  } mac_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic ev;
  } mac_flags_t;

endpackage

// File: rtl/mac_prod_chk.sv
module mac_prod_chk #(
  parameter int DATA_W = 64,
  parameter int PROD_W = 40,
  parameter int BIG_SH = 50
) (
  input  logic [DATA_W-1:0] val,
  input  logic              is_signed,
  input  logic              sat,
  output logic [DATA_W-1:0] prod,
  output logic              ovf
);
  localparam int HI = DATA_W - PROD_W;
  localparam logic [DATA_W-1:0] BIG = DATA_W'(1) << BIG_SH;

  logic [PROD_W-1:0] lo;
  logic              s_ok, u_ok;

  assign lo   = val[PROD_W-1:0];
  assign s_ok = (val[DATA_W-1:PROD_W-1] == {(HI+1){val[PROD_W-1]}});
  assign u_ok = (val[DATA_W-1:PROD_W] == '0);

  always_comb begin
    ovf = is_signed ? !s_ok : !u_ok;
    if (!ovf) begin
      prod = val;
    end else if (sat) begin
      prod = (is_signed && val[DATA_W-1]) ? (~BIG + DATA_W'(1)) : BIG;
    end else if (is_signed) begin
      prod = {{HI{lo[PROD_W-1]}}, lo};
    end else begin
      prod = {{HI{1'b0}}, lo};
    end
  end
endmodule

// File: rtl/mac_acc_sat.sv
module mac_acc_sat #(
  parameter int DATA_W = 64,
  parameter int ACC_W  = 48,
  parameter int RD_W   = 32
) (
  input  logic [DATA_W-1:0] val,
  input  logic              is_signed,
  input  logic              frac,
  input  logic              sat,
  output logic [DATA_W-1:0] acc,
  output logic              ovf
);
  localparam int HI = DATA_W - ACC_W;
  localparam logic [DATA_W-1:0] POS_ACC = {{(HI+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] POS_RD  = {{(DATA_W-RD_W+1){1'b0}}, {(RD_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] U_MAX   = {{HI{1'b0}}, {ACC_W{1'b1}}};

  logic [ACC_W-1:0] lo;
  logic             s_ok, u_ok, neg;

  assign lo   = val[ACC_W-1:0];
  assign neg  = val[DATA_W-1];
  assign s_ok = (val[DATA_W-1:ACC_W-1] == {(HI+1){val[ACC_W-1]}});
  assign u_ok = (val[DATA_W-1:ACC_W] == '0);

  always_comb begin
    ovf = is_signed ? !s_ok : !u_ok;
    if (!ovf) begin
      acc = val;
    end else if (!is_signed) begin
      acc = sat ? U_MAX : {{HI{1'b0}}, lo};
    end else if (!sat) begin
      acc = {{HI{lo[ACC_W-1]}}, lo};
    end else if (frac) begin
      acc = neg ? ~POS_ACC : POS_ACC;
    end else begin
      acc = neg ? ~POS_RD : POS_RD;
    end
  end
endmodule

// File: rtl/mac_rnd_even.sv
module mac_rnd_even #(
  parameter int DATA_W = 64,
  parameter int SH     = 24,
  parameter int OUT_W  = 16
) (
  input  logic [DATA_W-1:0] val,
  input  logic              en,
  input  logic              sat,
  output logic [OUT_W-1:0]  q_out
);
  localparam logic [SH-1:0] HALF = SH'(1) << (SH - 1);

  logic [DATA_W-1:0] q, qi;
  logic [SH-1:0]     rem;
  logic              up, fits;

  assign q    = DATA_W'($signed(val) >>> SH);
  assign rem  = val[SH-1:0];
  assign up   = en && ((rem > HALF) || ((rem == HALF) && q[0]));
  assign qi   = q + {{(DATA_W-1){1'b0}}, up};
  assign fits = (qi[DATA_W-1:OUT_W-1] == {(DATA_W-OUT_W+1){qi[OUT_W-1]}});

  always_comb begin
    if (sat && !fits) begin
      q_out = qi[DATA_W-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
    end else begin
      q_out = qi[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/mac_flag_eval.sv
module mac_flag_eval #(
  parameter int ACC_W  = 48,
  parameter int PROD_W = 40,
  parameter int RD_W   = 32
) (
  input  logic [ACC_W-1:0] a,
  input  logic             frac,
  input  logic             sgn,
  output logic             z,
  output logic             n,
  output logic             ev
);
  logic [ACC_W-PROD_W-1:0] ext_f;
  logic [ACC_W-RD_W-1:0]   ext_i;

  assign ext_f = a[ACC_W-1:PROD_W];
  assign ext_i = a[ACC_W-1:RD_W];
  assign z     = (a == '0);
  assign n     = a[ACC_W-1];

  always_comb begin
    if (frac)      ev = !((ext_f == '0) || (ext_f == '1));
    else if (sgn)  ev = !((ext_i == '0) || (ext_i == '1));
    else           ev = (ext_i != '0);
  end
endmodule

// File: rtl/mac_result_path.sv
module mac_result_path #(
  parameter int DATA_W  = 64,
  parameter int ACC_W   = 48,
  parameter int PROD_W  = 40,
  parameter int RD_W    = 32,
  parameter int HALF_W  = 16,
  parameter int HALF_SH = 24,
  parameter int RND_SH  = 8,
  parameter int BIG_SH  = 50,
  parameter int NUM_ACC = 4,
  localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_op,
  input  logic [SEL_W-1:0]   in_sel,
  input  logic [DATA_W-1:0]  in_val,
  input  logic               mode_frac,
  input  logic               mode_signed,
  input  logic               mode_round,
  input  logic               mode_half,
  input  logic               mode_sat,
  input  logic               flag_clr,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [DATA_W-1:0]  res_data,
  output logic               flag_z,
  output logic               flag_n,
  output logic               flag_v,
  output logic               flag_ev,
  output logic [NUM_ACC-1:0] flag_pav
);
  import mac_rp_pkg::*;

  localparam logic [DATA_W-1:0] RD_POS = {{(DATA_W-RD_W+1){1'b0}}, {(RD_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] RD_NEG = {{(DATA_W-RD_W){1'b0}}, 1'b1, {(RD_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] RD_ONES = {{(DATA_W-RD_W){1'b0}}, {RD_W{1'b1}}};

  mac_op_e            op;
  logic               accept, is_signed;
  logic [DATA_W-1:0]  prod_w, sat_w, rd_w, nxt_data;
  logic               prod_ovf, sat_ovf;
  logic [HALF_W-1:0]  r_half;
  logic [RD_W-1:0]    r_word;
  logic               ev_z, ev_n, ev_ev;
  mac_flags_t         cur_f, base_f, nxt_f;
  logic [NUM_ACC-1:0] base_pav, nxt_pav;

  assign op        = mac_op_e'(in_op);
  assign in_ready  = !res_valid || res_ready;
  assign accept    = in_valid && in_ready;
  assign is_signed = mode_frac || mode_signed;

  mac_prod_chk #(.DATA_W(DATA_W), .PROD_W(PROD_W), .BIG_SH(BIG_SH)) prod_i (
    .val(in_val), .is_signed(is_signed), .sat(mode_sat), .prod(prod_w), .ovf(prod_ovf)
  );

  mac_acc_sat #(.DATA_W(DATA_W), .ACC_W(ACC_W), .RD_W(RD_W)) sat_i (
    .val(in_val), .is_signed(is_signed), .frac(mode_frac), .sat(mode_sat),
    .acc(sat_w), .ovf(sat_ovf)
  );

  mac_rnd_even #(.DATA_W(DATA_W), .SH(HALF_SH), .OUT_W(HALF_W)) rnd_half_i (
    .val(in_val), .en(1'b1), .sat(mode_sat), .q_out(r_half)
  );

  mac_rnd_even #(.DATA_W(DATA_W), .SH(RND_SH), .OUT_W(RD_W)) rnd_word_i (
    .val(in_val), .en(mode_round), .sat(mode_sat), .q_out(r_word)
  );

  mac_flag_eval #(.ACC_W(ACC_W), .PROD_W(PROD_W), .RD_W(RD_W)) flg_i (
    .a(in_val[ACC_W-1:0]), .frac(mode_frac), .sgn(mode_signed),
    .z(ev_z), .n(ev_n), .ev(ev_ev)
  );

  // Plain integer read-back and read path selection
  always_comb begin
    logic fits32;
    fits32 = (in_val[DATA_W-1:RD_W-1] == {(DATA_W-RD_W+1){in_val[RD_W-1]}});
    if (mode_frac) begin
      rd_w = mode_half ? {{(DATA_W-HALF_W){1'b0}}, r_half}
                       : {{(DATA_W-RD_W){1'b0}}, r_word};
    end else if (mode_signed) begin
      if (fits32) rd_w = {{(DATA_W-RD_W){1'b0}}, in_val[RD_W-1:0]};
      else        rd_w = in_val[DATA_W-1] ? RD_NEG : RD_POS;
    end else begin
      if (in_val[DATA_W-1:RD_W] == '0) rd_w = {{(DATA_W-RD_W){1'b0}}, in_val[RD_W-1:0]};
      else                             rd_w = RD_ONES;
    end
  end

  // Flag update: clear first, then the accepted operation's effects
  always_comb begin
    cur_f    = '{z: flag_z, n: flag_n, v: flag_v, ev: flag_ev};
    base_f   = flag_clr ? '0 : cur_f;
    base_pav = flag_clr ? '0 : flag_pav;
    nxt_f    = base_f;
    nxt_pav  = base_pav;
    nxt_data = '0;
    if (accept) begin
      unique case (op)
        OP_MUL: begin
          nxt_data = prod_w;
          nxt_f.v  = base_f.v | prod_ovf;
        end
        OP_SAT: begin
          nxt_data        = sat_w;
          nxt_f.v         = base_f.v | sat_ovf;
          nxt_pav[in_sel] = base_pav[in_sel] | sat_ovf;
        end
        OP_FLAGS: begin
          nxt_f.z  = ev_z;
          nxt_f.n  = ev_n & ~ev_z;
          nxt_f.ev = ev_ev;
          nxt_f.v  = base_f.v | base_pav[in_sel];
        end
        default: begin
          nxt_data = rd_w;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      flag_z    <= 1'b0;
      flag_n    <= 1'b0;
      flag_v    <= 1'b0;
      flag_ev   <= 1'b0;
      flag_pav  <= '0;
    end else begin
      if (accept) begin
        res_valid <= 1'b1;
        res_data  <= nxt_data;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
      flag_z   <= nxt_f.z;
      flag_n   <= nxt_f.n;
      flag_v   <= nxt_f.v;
      flag_ev  <= nxt_f.ev;
      flag_pav <= nxt_pav;
    end
  end
endmodule

// File: rtl/mac_result_path_chk.sv
module mac_result_path_chk #(
  parameter int DATA_W  = 64,
  parameter int NUM_ACC = 4,
  parameter int SEL_W   = 2,
  parameter int RD_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [1:0]         in_op,
  input logic [SEL_W-1:0]   in_sel,
  input logic               flag_clr,
  input logic               res_valid,
  input logic               res_ready,
  input logic [DATA_W-1:0]  res_data,
  input logic               flag_v,
  input logic               flag_ev,
  input logic [NUM_ACC-1:0] flag_pav
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> res_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  p_one_pav_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(flag_pav & ~$past(flag_pav)) <= 1);

  p_v_from_pav_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 2'd2 && !flag_clr && flag_pav[in_sel] |=> flag_v);

  p_read_zext_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 2'd3 |=> res_data[DATA_W-1:RD_W] == '0);

  p_pav_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr |=> (flag_pav & $past(flag_pav)) == $past(flag_pav));

  p_v_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr && flag_v |=> flag_v);

  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !(in_valid && in_ready) |=> !flag_v && !flag_ev && flag_pav == '0);
endmodule

bind mac_result_path mac_result_path_chk #(
  .DATA_W(DATA_W), .NUM_ACC(NUM_ACC), .SEL_W(SEL_W), .RD_W(RD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_sel(in_sel), .flag_clr(flag_clr), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data), .flag_v(flag_v),
  .flag_ev(flag_ev), .flag_pav(flag_pav)
);

// File: tb/mac_result_path_tb.sv
module mac_result_path_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'd0;
  logic [1:0]  in_sel = 2'd0;
  logic [63:0] in_val = 64'd0;
  logic        mode_frac = 1'b0, mode_signed = 1'b0, mode_round = 1'b0;
  logic        mode_half = 1'b0, mode_sat = 1'b0, flag_clr = 1'b0;
  logic        res_valid, res_ready;
  logic [63:0] res_data;
  logic        flag_z, flag_n, flag_v, flag_ev;
  logic [3:0]  flag_pav;

  int total = 0, bad = 0, cyc = 0;
  bit backp = 1'b0, done = 1'b0;

  always #2 clk = ~clk;

  mac_result_path dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_sel(in_sel), .in_val(in_val), .mode_frac(mode_frac),
    .mode_signed(mode_signed), .mode_round(mode_round), .mode_half(mode_half),
    .mode_sat(mode_sat), .flag_clr(flag_clr), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .flag_z(flag_z), .flag_n(flag_n),
    .flag_v(flag_v), .flag_ev(flag_ev), .flag_pav(flag_pav)
  );

  // consumer pattern, changed between edges
  always @(negedge clk) begin
    cyc++;
    res_ready <= backp ? (cyc % 3 == 0) : 1'b1;
  end
  initial res_ready = 1'b1;

  // ---------------- reference model ----------------
  bit          m_valid;
  bit [63:0]   m_data;
  bit          m_z, m_n, m_v, m_ev;
  bit [3:0]    m_pav;
  string       m_tag = "R1";

  function automatic longint sx(bit [63:0] v, int w);
    longint t = longint'(v << (64 - w));
    return t >>> (64 - w);
  endfunction

  function automatic bit [63:0] rnd_read(longint s, int sh, bit en, bit sat, int w);
    longint q = s >>> sh;
    longint rem = s & ((longint'(1) <<< sh) - 1);
    longint h = longint'(1) <<< (sh - 1);
    longint lim = longint'(1) <<< (w - 1);
    if (en && (rem > h || (rem == h && (q & 1) != 0))) q = q + 1;
    if (sat && q > lim - 1) q = lim - 1;
    if (sat && q < -lim) q = -lim;
    return bit'(1) ? (64'(q) & ((64'd1 << w) - 1)) : 64'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_data = 0; m_z = 0; m_n = 0; m_v = 0; m_ev = 0; m_pav = 0;
    end else begin
      bit take;
      bit [63:0] v;
      longint s;
      bit sg;
      take = in_valid && (!m_valid || res_ready);
      if (!take && res_ready) m_valid = 0;
      if (flag_clr) begin m_z = 0; m_n = 0; m_v = 0; m_ev = 0; m_pav = 0; end
      if (take) begin
        v = in_val; s = longint'(in_val); sg = mode_frac || mode_signed;
        m_valid = 1;
        case (in_op)
          2'd0: begin
            if (sg) begin
              m_tag = "R3";
              if (s < -(longint'(1) <<< 39) || s > (longint'(1) <<< 39) - 1) begin
                m_v = 1;
                m_data = mode_sat ? (s < 0 ? 64'(-(longint'(1) <<< 50)) : 64'd1 << 50) : 64'(sx(v, 40));
              end else m_data = v;
            end else begin
              m_tag = "R4";
              if (v >= (64'd1 << 40)) begin
                m_v = 1;
                m_data = mode_sat ? (64'd1 << 50) : (v & ((64'd1 << 40) - 1));
              end else m_data = v;
            end
          end
          2'd1: begin
            if (sg) begin
              m_tag = "R5";
              if (s < -(longint'(1) <<< 47) || s > (longint'(1) <<< 47) - 1) begin
                m_v = 1; m_pav[in_sel] = 1;
                if (!mode_sat) m_data = 64'(sx(v, 48));
                else if (mode_frac) m_data = s < 0 ? 64'(-(longint'(1) <<< 47)) : (64'd1 << 47) - 1;
                else m_data = s < 0 ? 64'(-(longint'(1) <<< 31)) : (64'd1 << 31) - 1;
              end else m_data = v;
            end else begin
              m_tag = "R6";
              if (v >= (64'd1 << 48)) begin
                m_v = 1; m_pav[in_sel] = 1;
                m_data = mode_sat ? (64'd1 << 48) - 1 : (v & ((64'd1 << 48) - 1));
              end else m_data = v;
            end
          end
          2'd2: begin
            bit [47:0] a;
            bit [15:0] e;
            m_tag = "R7";
            a = v[47:0]; e = a[47:32];
            m_data = 0;
            m_z = (a == 0); m_n = a[47];
            if (m_pav[in_sel]) m_v = 1;
            if (mode_frac) m_ev = !(a[47:40] == 8'h00 || a[47:40] == 8'hFF);
            else if (mode_signed) m_ev = !(e == 16'h0000 || e == 16'hFFFF);
            else m_ev = (e != 0);
          end
          default: begin
            if (mode_frac && mode_half) begin
              m_tag = "R9"; m_data = rnd_read(s, 24, 1'b1, mode_sat, 16);
            end else if (mode_frac) begin
              m_tag = "R10"; m_data = rnd_read(s, 8, mode_round, mode_sat, 32);
            end else if (mode_signed) begin
              m_tag = "R11";
              if (s >= -(longint'(1) <<< 31) && s <= (longint'(1) <<< 31) - 1) m_data = v & 64'hFFFF_FFFF;
              else m_data = s < 0 ? 64'h8000_0000 : 64'h7FFF_FFFF;
            end else begin
              m_tag = "R11";
              m_data = (v >> 32) == 0 ? v : 64'hFFFF_FFFF;
            end
          end
        endcase
      end
    end
  end

  // ---------------- comparator, away from the edge ----------------
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      total++;
      if (res_valid !== m_valid || in_ready !== (!m_valid || res_ready)) begin
        bad++;
        $display("FAIL R2 handshake: actual valid=%0b ready=%0b expected valid=%0b ready=%0b",
                 res_valid, in_ready, m_valid, !m_valid || res_ready);
      end else if (m_valid && res_data !== m_data) begin
        bad++;
        $display("FAIL %s data: actual=%h expected=%h", m_tag, res_data, m_data);
      end else if (flag_v !== m_v || flag_pav !== m_pav) begin
        bad++;
        $display("FAIL R12 sticky: actual v=%0b pav=%b expected v=%0b pav=%b",
                 flag_v, flag_pav, m_v, m_pav);
      end else if (flag_z !== m_z || flag_n !== m_n) begin
        bad++;
        $display("FAIL R7 zn: actual=%0b%0b expected=%0b%0b", flag_z, flag_n, m_z, m_n);
      end else if (flag_ev !== m_ev) begin
        bad++;
        $display("FAIL R8 ev: actual=%0b expected=%0b", flag_ev, m_ev);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [1:0] op, input logic [4:0] md,
                      input logic [1:0] sel, input logic [63:0] val);
    @(negedge clk);
    in_op = op; in_sel = sel; in_val = val; in_valid = 1'b1;
    {mode_frac, mode_signed, mode_round, mode_half, mode_sat} = md;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // mode vectors {frac, signed, round, half, sat}
  localparam logic [4:0] S_NS = 5'b01000, S_SA = 5'b01001, U_NS = 5'b00000, U_SA = 5'b00001;
  localparam logic [4:0] F_NS = 5'b10000, F_SA = 5'b10001, F_RD = 5'b10100, F_RS = 5'b10101;
  localparam logic [4:0] H_NS = 5'b10010, H_SA = 5'b10011;

  task automatic run_all();
    // R3: signed product range
    send(2'd0, S_NS, 0, 64'h0000_007F_FFFF_FFFF);
    send(2'd0, S_SA, 0, 64'h0000_0080_0000_0000);
    send(2'd0, S_NS, 0, 64'hFFFF_FF80_0000_0000);
    send(2'd0, F_NS, 0, 64'hFFFF_FF7F_FFFF_FFFF);
    send(2'd0, S_SA, 0, 64'hFFFF_F000_0000_0001);
    clear_flags();
    // R4: unsigned product
    send(2'd0, U_NS, 1, 64'h0000_00FF_FFFF_FFFF);
    send(2'd0, U_SA, 1, 64'h0000_0100_0000_0000);
    send(2'd0, U_NS, 1, 64'h0000_0123_4567_89AB);
    // R5 / R6: accumulator saturation into different accumulators
    send(2'd1, S_NS, 2, 64'h0000_7FFF_FFFF_FFFF);
    send(2'd1, S_SA, 2, 64'h0000_8000_0000_0000);
    send(2'd1, F_SA, 3, 64'hFFFF_7FFF_FFFF_FFFF);
    send(2'd1, F_NS, 1, 64'h0001_2345_6789_ABCD);
    send(2'd1, U_SA, 0, 64'h0001_0000_0000_0000);
    send(2'd1, U_NS, 0, 64'h0002_1234_5678_9ABC);
    // R7 / R8: flags and extension checks
    send(2'd2, S_NS, 2, 64'd0);
    send(2'd2, S_NS, 1, 64'hFFFF_FFFF_FFFF_FFFB);
    send(2'd2, F_NS, 0, 64'h0000_0100_0000_0000);
    send(2'd2, F_NS, 0, 64'hFFFF_FF80_0000_0000);
    send(2'd2, U_NS, 0, 64'h0000_0001_0000_0000);
    clear_flags();
    send(2'd2, S_NS, 2, 64'h0000_0000_0000_0005);
    send(2'd2, U_NS, 3, 64'h0000_0000_FFFF_FFFF);
    // R9: 16-bit fractional rounding and saturation
    send(2'd3, H_NS, 0, 64'h0000_0012_3480_0000);
    send(2'd3, H_NS, 0, 64'h0000_0012_3580_0000);
    send(2'd3, H_NS, 0, 64'h0000_0012_3480_0001);
    send(2'd3, H_SA, 0, 64'h0000_7FFF_8000_0000);
    send(2'd3, H_SA, 0, 64'hFFFF_8000_0000_0000);
    send(2'd3, H_NS, 0, 64'hFFFF_FFFF_FF80_0000);
    // R10: 32-bit fractional read
    send(2'd3, F_RD, 0, 64'h0000_0001_0000_0080);
    send(2'd3, F_RD, 0, 64'h0000_0001_0000_0180);
    send(2'd3, F_NS, 0, 64'h0000_0001_0000_01FF);
    send(2'd3, F_RS, 0, 64'h0000_007F_FFFF_FF80);
    send(2'd3, F_SA, 0, 64'hFFFF_8000_0000_0000);
    send(2'd3, F_RD, 0, 64'hFFFF_FFFF_FFFF_FF81);
    // R11: plain reads
    send(2'd3, S_NS, 0, 64'h0000_0001_0000_0000);
    send(2'd3, S_NS, 0, 64'hFFFF_FFFF_0000_0000);
    send(2'd3, S_NS, 0, 64'hFFFF_FFFF_FFFF_FFFB);
    send(2'd3, U_NS, 0, 64'h0000_0000_DEAD_BEEF);
    send(2'd3, U_NS, 0, 64'h0000_0001_0000_0000);
    // R12: clear with a same-edge overflow
    @(negedge clk);
    flag_clr = 1'b1; in_op = 2'd1; in_sel = 2'd1; in_val = 64'h0001_0000_0000_0000;
    {mode_frac, mode_signed, mode_round, mode_half, mode_sat} = U_NS; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk); flag_clr = 1'b0; in_valid = 1'b0;
    repeat (4) @(negedge clk);
    clear_flags();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    total++;
    if (res_valid !== 1'b0 || in_ready !== 1'b1 || flag_v !== 1'b0 || flag_pav !== 4'd0 ||
        flag_z !== 1'b0 || flag_n !== 1'b0 || flag_ev !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: actual valid=%0b v=%0b pav=%b expected 0 0 0000",
               res_valid, flag_v, flag_pav);
    end
    run_all();
    backp = 1'b1;
    run_all();
    backp = 1'b0;
    repeat (6) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule